// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside the receive path of an Ethernet MAC and decides whether a frame should be kept, judging only its 48-bit destination address. The receive logic presents the six address bytes in wire order, one per clock when `byte_valid_i` is high, and marks the first byte with `start_i`. Two clocks after the sixth byte has been taken, the block pulses `done_o` for one cycle and presents its verdict on `accept_o`. The verdict holds there until the next verdict.

A frame is kept when promiscuous mode is on, or when its address equals the station address, or when it is the all-ones broadcast address and broadcast rejection is off. A group (multicast) address other than broadcast is kept when one bit of a 64-bit hash table is set. That bit is picked by the top six bits of the Ethernet CRC-32, which the block computes over the six address bytes as they arrive. The station address, the hash table and the control bits come in as static configuration words from registers that the block does not own.

Top module: `rx_dest_filter`

## Requirements
- R1: During and right after reset, `done_o` and `accept_o` are both 0.
- R2: A frame is a byte with `start_i` and `byte_valid_i` both high, followed by five more valid bytes. Idle cycles may come between the bytes. `done_o` is high for exactly one cycle: the second clock cycle after the edge that takes the sixth byte.
- R3: The frame is accepted when its bytes b0..b5 (b0 first) match the station words. `station_hi_i[15:8]`=b0, `station_hi_i[7:0]`=b1, `station_lo_i[31:24]`=b2, and so on down to `station_lo_i[7:0]`=b5.
- R4: An all-ones address is accepted when `ctrl_i[3]` is 0. When `ctrl_i[3]` is 1 it is rejected, whatever the hash table holds, unless R3 or R7 applies.
- R5: A group address is one with bit 0 of b0 set. For a group address that is not all ones, the block runs a CRC over b0..b5, each byte LSB first. The CRC register starts at all ones, uses polynomial 0x04C11DB7 shifting towards the MSB, and gets no final inversion. Its bits 31:26 form an index. Index bit 5 picks `hash_hi_i` (1) or `hash_lo_i` (0), and index bits 4:0 pick the bit within that word. The frame is accepted exactly when that bit is 1.
- R6: With both hash words all ones, every group address that is not all ones is accepted.
- R7: With `ctrl_i[5]` set (promiscuous), every frame is accepted, including a broadcast while `ctrl_i[3]` is set.
- R8: An individual address (bit 0 of b0 clear) that differs from the station address is rejected, even with a full hash table.
- R9: Valid bytes without `start_i` while no frame is open, or after six bytes have been taken, are ignored and produce no `done_o`.
- R10: A byte with `start_i` arriving partway through a frame abandons that frame and begins a new one with itself as b0.
- R11: `accept_o` keeps its value between `done_o` pulses, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Marks the first address byte |
| byte_valid_i | input | 1 | Address byte strobe |
| byte_i | input | 8 | Address byte, wire order |
| station_lo_i | input | 32 | Station bytes b2 (31:24) to b5 (7:0) |
| station_hi_i | input | 16 | Station bytes b0 (15:8) and b1 (7:0) |
| hash_lo_i | input | 32 | Hash bins 0 to 31 |
| hash_hi_i | input | 32 | Hash bins 32 to 63 |
| ctrl_i | input | 8 | Bit 3 rejects broadcast, bit 5 is promiscuous |
| done_o | output | 1 | One-cycle verdict strobe |
| accept_o | output | 1 | Verdict, held until the next strobe |

## Verification
The bench sets, for a given multicast address, either only the one hash bin it predicts or every bin except that one. A CRC with the wrong bit order, seed or index slice, or a swapped hash word, would then flip the verdict. Broadcast is tried with broadcast rejection on and a full hash table, which catches a design that lets the all-ones address win through the multicast rule. Stray bytes without a start and a restart partway through a frame are also driven: a counter that does not reset on start would strobe early or judge a mixed address. Latency is checked on both sides of the strobe, and the verdict is checked for holding while inputs change between frames.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int CTRL_BCAST_REJ_BIT = 3;
    localparam int CTRL_PROMISC_BIT   = 5;
endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture #(
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [7:0]        byte_i,
    output logic              take_o,
    output logic              first_o,
    output logic              eval_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              eval;
    } cap_t;

    cap_t st_d, st_q;
    logic take, open;

    always_comb begin
        st_d      = st_q;
        st_d.eval = 1'b0;
        open      = (st_q.cnt != '0) && (st_q.cnt < LAST);
        take      = valid_i && (start_i || open);
        if (take) begin
            st_d.cnt  = start_i ? CNT_W'(1) : st_q.cnt + CNT_W'(1);
            st_d.addr = {st_q.addr[ADDR_W-9:0], byte_i};
            st_d.eval = (st_d.cnt == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o  = take;
    assign first_o = start_i;
    assign eval_o  = st_q.eval;
    assign addr_o  = st_q.addr;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST); // R2
    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && valid_i && !start_i) |=> (st_q.cnt == '0 && !st_q.eval)); // R9
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && start_i) |=> (st_q.cnt == CNT_W'(1))); // R10
endmodule

// File: rtl/rxf_crc_engine.sv
module rxf_crc_engine #(
    parameter int CRC_W = 32,
    parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             first_i,
    input  logic [7:0]       byte_i,
    output logic [CRC_W-1:0] crc_o
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_st_t;

    crc_st_t st_d, st_q;
    logic [CRC_W-1:0] stage [0:8];

    assign stage[0] = first_i ? {CRC_W{1'b1}} : st_q.crc;

    for (genvar b = 0; b < 8; b++) begin : g_bit
        logic fb;
        assign fb = stage[b][CRC_W-1] ^ byte_i[b];
        assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

    always_comb begin
        st_d = st_q;
        if (take_i) st_d.crc = stage[8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{crc: {CRC_W{1'b1}}};
        else        st_q <= st_d;
    end

    assign crc_o = st_q.crc;

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(st_q.crc)); // R5
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 6,
    localparam int HASH_W = 2 ** IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ADDR_W-1:0] station_i,
    input  logic [HASH_W-1:0] hash_i,
    input  logic              bcast_rej_i,
    input  logic              promisc_i,
    output logic              done_o,
    output logic              accept_o
);
    typedef struct packed {
        logic done;
        logic accept;
    } dec_t;

    dec_t st_d, st_q;
    logic is_bcast, is_group, is_station, hash_hit, verdict;

    always_comb begin
        is_bcast   = &addr_i;
        is_group   = addr_i[ADDR_W-8];
        is_station = (addr_i == station_i);
        hash_hit   = hash_i[idx_i];
        verdict    = promisc_i || is_station ||
                     (is_bcast && !bcast_rej_i) ||
                     (is_group && !is_bcast && hash_hit);
        st_d       = st_q;
        st_d.done  = eval_i;
        if (eval_i) st_d.accept = verdict;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o   = st_q.done;
    assign accept_o = st_q.accept;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R2
    AST_DONE_AFTER_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i |=> st_q.done); // R2
    AST_PROMISC: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && promisc_i) |=> st_q.accept); // R7
    AST_BCAST_REJ: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && (&addr_i) && bcast_rej_i && !promisc_i && addr_i != station_i)
        |=> !st_q.accept); // R4
    AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> $stable(st_q.accept)); // R11
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int CRC_W = 32,
    parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7,
    parameter int IDX_W = 6,
    localparam int ADDR_W = 8 * ADDR_BYTES,
    localparam int HALF_W = 2 ** (IDX_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    input  logic [31:0]       station_lo_i,
    input  logic [ADDR_W-33:0] station_hi_i,
    input  logic [HALF_W-1:0] hash_lo_i,
    input  logic [HALF_W-1:0] hash_hi_i,
    input  logic [7:0]        ctrl_i,
    output logic              done_o,
    output logic              accept_o
);
    import rxf_pkg::*;

    logic              take, first, eval;
    logic [ADDR_W-1:0] addr;
    logic [CRC_W-1:0]  crc;
    logic              unused_bits;

    assign unused_bits = ^{crc[CRC_W-IDX_W-1:0], ctrl_i[7:6], ctrl_i[4], ctrl_i[2:0]};

    rxf_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(byte_valid_i),
        .byte_i(byte_i), .take_o(take), .first_o(first), .eval_o(eval), .addr_o(addr)
    );

    rxf_crc_engine #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .take_i(take), .first_i(first),
        .byte_i(byte_i), .crc_o(crc)
    );

    rxf_decide #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .eval_i(eval), .addr_i(addr),
        .idx_i(crc[CRC_W-1 -: IDX_W]), .station_i({station_hi_i, station_lo_i}),
        .hash_i({hash_hi_i, hash_lo_i}),
        .bcast_rej_i(ctrl_i[CTRL_BCAST_REJ_BIT]), .promisc_i(ctrl_i[CTRL_PROMISC_BIT]),
        .done_o(done_o), .accept_o(accept_o)
    );
endmodule

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, byte_valid_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic [31:0] station_lo_i = 32'h2233_4455;
    logic [15:0] station_hi_i = 16'h0211;
    logic [31:0] hash_lo_i = '0, hash_hi_i = '0;
    logic [7:0] ctrl_i = '0;
    logic done_o, accept_o;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rx_dest_filter u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .station_lo_i(station_lo_i), .station_hi_i(station_hi_i),
        .hash_lo_i(hash_lo_i), .hash_hi_i(hash_hi_i), .ctrl_i(ctrl_i),
        .done_o(done_o), .accept_o(accept_o)
    );

    typedef struct packed {
        logic [47:0] addr;
        logic [7:0]  ctrl;
        logic [1:0]  hm;    // 0: both words = fill, 1: only predicted bin, 2: all but predicted bin
        logic [31:0] fill;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{48'h0211_2233_4455, 8'h00, 2'd0, 32'h0,        1'b1, 4'd3},  // R3 station hit
        '{48'h0211_2233_4456, 8'h00, 2'd0, 32'h0,        1'b0, 4'd8},  // R8 other unicast
        '{48'h0211_2233_4456, 8'h00, 2'd0, 32'hFFFFFFFF, 1'b0, 4'd8},  // R8 hash ignored for unicast
        '{48'hFFFF_FFFF_FFFF, 8'h00, 2'd0, 32'h0,        1'b1, 4'd4},  // R4 broadcast kept
        '{48'hFFFF_FFFF_FFFF, 8'h08, 2'd0, 32'hFFFFFFFF, 1'b0, 4'd4},  // R4 broadcast rejected
        '{48'h0100_5E00_0001, 8'h00, 2'd1, 32'h0,        1'b1, 4'd5},  // R5 only predicted bin
        '{48'h0100_5E00_0001, 8'h00, 2'd2, 32'h0,        1'b0, 4'd5},  // R5 all bins but predicted
        '{48'h3333_0000_0001, 8'h00, 2'd1, 32'h0,        1'b1, 4'd5},  // R5 second group address
        '{48'h0180_C200_0000, 8'h00, 2'd0, 32'hFFFFFFFF, 1'b1, 4'd6},  // R6 full table
        '{48'h0A00_0000_0001, 8'h20, 2'd0, 32'h0,        1'b1, 4'd7},  // R7 promiscuous unicast
        '{48'hFFFF_FFFF_FFFF, 8'h28, 2'd0, 32'h0,        1'b1, 4'd7},  // R7 promiscuous beats reject
        '{48'h0100_5E7F_0001, 8'h00, 2'd2, 32'h0,        1'b0, 4'd5}   // R5 empty bin
    };

    function automatic logic [31:0] model_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = a[47 - 8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                logic fb = c[31] ^ b[j];
                c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bytes(input logic [47:0] a, input int nbytes, input int gap);
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            start_i = (i == 0);
            byte_valid_i = 1'b1;
            byte_i = a[47 - 8*i -: 8];
            if (gap > 0 && i < nbytes - 1) begin
                @(negedge clk);
                start_i = 1'b0; byte_valid_i = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
    endtask

    // sends a full address and checks R2 latency; returns verdict
    task automatic frame(input logic [47:0] a, input int gap, input string req, output logic acc);
        logic d1, d2, d3;
        send_bytes(a, 6, gap);
        @(negedge clk); start_i = 1'b0; byte_valid_i = 1'b0; d1 = done_o;
        @(negedge clk); d2 = done_o; acc = accept_o;
        @(negedge clk); d3 = done_o;
        check(!d1 && d2 && !d3, req, {d1, d2, d3}, 3'b010);
    endtask

    initial begin
        logic acc;
        logic [63:0] h;
        logic [31:0] c;
        int seen;
        repeat (3) @(negedge clk);
        check(done_o == 1'b0 && accept_o == 1'b0, "R1 in reset", {done_o, accept_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 1'b0 && accept_o == 1'b0, "R1 after reset", {done_o, accept_o}, 0);

        for (int v = 0; v < NV; v++) begin
            c = model_crc(VECS[v].addr);
            case (VECS[v].hm)
                2'd1:    h = 64'd1 << c[31:26];
                2'd2:    h = ~(64'd1 << c[31:26]);
                default: h = {VECS[v].fill, VECS[v].fill};
            endcase
            hash_hi_i = h[63:32]; hash_lo_i = h[31:0];
            ctrl_i = VECS[v].ctrl;
            frame(VECS[v].addr, 0, "R2 latency", acc);
            checks++;
            if (acc !== VECS[v].exp) begin
                failures++;
                $display("FAIL R%0d vector %0d actual=%0b expected=%0b", VECS[v].req, v, acc, VECS[v].exp);
            end
        end

        // R2 with idle gaps between bytes
        hash_hi_i = '0; hash_lo_i = '0; ctrl_i = '0;
        frame(48'h0211_2233_4455, 2, "R2 gapped", acc);
        check(acc == 1'b1, "R2 gapped verdict", acc, 1);

        // R9 stray bytes with no start, then after a finished frame
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); start_i = 1'b0; byte_valid_i = 1'b1; byte_i = 8'hFF;
            if (done_o) seen++;
        end
        @(negedge clk); byte_valid_i = 1'b0; if (done_o) seen++;
        @(negedge clk); if (done_o) seen++;
        @(negedge clk); if (done_o) seen++;
        check(seen == 0, "R9 stray bytes", seen, 0);

        // R11 hold: verdict 1 stays while inputs change and strays arrive
        check(accept_o == 1'b1, "R11 held before", accept_o, 1);
        ctrl_i = 8'h08; station_hi_i = 16'h0000;
        repeat (4) @(negedge clk);
        check(accept_o == 1'b1 && done_o == 1'b0, "R11 held after input change", {done_o, accept_o}, 1);
        station_hi_i = 16'h0211; ctrl_i = '0;

        // R10 restart partway: partial broadcast-like bytes then a full unicast miss
        send_bytes(48'hFFFF_FF00_0000, 3, 0);
        frame(48'h0211_2233_4466, 0, "R10 latency", acc);
        check(acc == 1'b0, "R10 restart verdict", acc, 0);
        // restart partway into a station hit
        send_bytes(48'h0A0B_0C0D_0E0F, 4, 0);
        frame(48'h0211_2233_4455, 0, "R10 latency 2", acc);
        check(acc == 1'b1, "R10 restart to station", acc, 1);

        // R3 byte mapping: swapping b0 and b1 must miss
        frame(48'h1102_2233_4455, 0, "R2 latency swap", acc);
        check(acc == 1'b0, "R3 byte order", acc, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule